// File: doc/BRIEF.md
# Critical-Word-First Cache Line Fill Engine

This block services a cache read miss. It takes the missing byte address, asks a narrow memory bus for the whole line starting at the chunk that holds that byte, and collects the returning beats in a line-wide holding buffer. The beats arrive in wrapped order: the critical chunk first, then the following chunks, wrapping past the end of the line back to its start.

As soon as the critical chunk lands, the block hands that chunk to the core on a forwarding port, together with the byte offset of the missed address inside the chunk. The core can then resume while the remaining beats stream in. Once every beat of the line is held, the block presents the complete line and its line address on a single-cycle write port toward the cache data array. Only then does it accept another miss.

With default parameters the bus beat is 8 bytes and a line is 32 bytes, so every fill takes four beats. A miss at byte 0x95 requests chunk 0x90, and the beats cover 0x90, 0x98, 0x80 and 0x88 in that order.

Top module: `cwf_line_fill`

## Requirements
- R1: After a synchronous active-low reset, `miss_ready` is 1 and `mem_req_valid`, `fwd_valid` and `line_wr_valid` are 0.
- R2: The cycle after a miss is accepted, `mem_req_valid` rises with `mem_req_addr` equal to the miss address with its low 3 bits cleared (line bits from bit 5 up, critical chunk index in bits [4:3]). The request is held stable until `mem_req_ready` is seen high.
- R3: Beat number n (counting from 0) of a fill is placed in line chunk (s + n) mod 4, where s is miss address bits [4:3]. Chunk k occupies `line_wr_data[64k+63:64k]`.
- R4: The cycle after the first beat is taken, `fwd_valid` is high for exactly one cycle, with `fwd_data` equal to that beat and `fwd_offset` equal to miss address bits [2:0].
- R5: The cycle after the fourth beat is taken, `line_wr_valid` is high for exactly one cycle, with `line_wr_addr` equal to miss address bits [31:5].
- R6: `miss_ready` is low from the cycle after a miss is accepted until the cycle after the line write. A `miss_valid` raised in that window starts no memory request and does not change the line being filled.
- R7: A response beat presented while the memory request is still waiting for `mem_req_ready` is ignored: it raises no forward and does not appear in the written line.
- R8: Each fill raises `fwd_valid` exactly once and `line_wr_valid` exactly once, and the forward comes before the line write.
- R9: Idle cycles between response beats and before `mem_req_ready` delay the outputs but leave the forwarded chunk and the written line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | A read miss is offered |
| miss_ready | output | 1 | The engine is idle and takes a miss |
| miss_addr | input | 32 | Byte address of the missed access |
| mem_req_valid | output | 1 | Wrapped line read request to memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Address of the critical chunk, 8-byte aligned |
| mem_rsp_valid | input | 1 | A response beat is on the bus |
| mem_rsp_data | input | 64 | Response beat data |
| fwd_valid | output | 1 | Critical chunk forwarded to the core |
| fwd_data | output | 64 | The critical chunk |
| fwd_offset | output | 3 | Byte offset of the missed address in the chunk |
| line_wr_valid | output | 1 | Complete line written to the cache data array |
| line_wr_addr | output | 27 | Line address (byte address bits 31:5) |
| line_wr_data | output | 256 | Complete line, chunk k in bits 64k+63:64k |

## Verification
A wrong starting index or a slipped beat counter shows up at the ports in two places: the request address carries the wrong chunk bits the cycle after acceptance, and the written line puts chunks in the wrong 64-bit lanes one cycle after the last beat. A control state that leaves the data phase early or late moves the line write off the cycle after the fourth beat and shifts when `miss_ready` returns. A buffer that listens to the bus outside the data phase corrupts the line on the very next write. Every beat pattern is unique to its line and chunk, so any misplacement is visible on the first fill that meets it.

// File: rtl/cwf_pkg.sv
// Shared types for the critical-word-first line fill engine.
package cwf_pkg;

    // Fill sequencing states, one fill in flight at a time.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REQ    = 2'd1,
        ST_DATA   = 2'd2,
        ST_COMMIT = 2'd3
    } fill_state_t;

endpackage

// File: rtl/cwf_wrap_seq.sv
// Wrapped chunk sequencer.
// Holds the critical chunk index and a beat counter; the slot for the
// current beat is start + count, wrapping naturally in IDX_W bits.
// Assumes BEATS is a power of two so that the wrap is a plain overflow.
module cwf_wrap_seq #(
    parameter int BEATS = 4,
    localparam int IDX_W = $clog2(BEATS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] start_idx,
    input  logic             step,
    output logic [IDX_W-1:0] slot_idx,
    output logic             is_first,
    output logic             is_last
);

    logic [IDX_W-1:0] start_q;
    logic [IDX_W-1:0] count_q;

    // Capture the starting chunk on a new fill, advance on each beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            count_q <= '0;
        end else if (load) begin
            start_q <= start_idx;
            count_q <= '0;
        end else if (step) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Slot position and first/last beat flags.
    always_comb begin
        slot_idx = start_q + count_q;
        is_first = (count_q == '0);
        is_last  = (count_q == IDX_W'(BEATS - 1));
    end

endmodule

// File: rtl/cwf_line_store.sv
// Line holding buffer.
// One register per chunk; a beat is written into the chunk slot named by
// wr_idx, so arrival order never decides placement.
module cwf_line_store #(
    parameter int BEAT_W = 64,
    parameter int BEATS  = 4,
    localparam int IDX_W  = $clog2(BEATS),
    localparam int LINE_W = BEAT_W * BEATS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BEAT_W-1:0] wr_data,
    output logic [LINE_W-1:0] line_data
);

    for (genvar k = 0; k < BEATS; k++) begin : g_slot
        logic [BEAT_W-1:0] slot_q;

        // Store the incoming beat when it targets this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(k))) begin
                slot_q <= wr_data;
            end
        end

        assign line_data[k*BEAT_W +: BEAT_W] = slot_q;
    end

endmodule

// File: rtl/cwf_fill_ctrl.sv
// Fill control state machine.
// Idle -> request -> data -> commit -> idle. Beats count only in the data
// state; the commit state lasts one cycle and drives the line write.
module cwf_fill_ctrl
    import cwf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic miss_valid,
    input  logic mem_req_ready,
    input  logic mem_rsp_valid,
    input  logic last_beat,
    output logic accept,
    output logic beat_take,
    output logic idle,
    output logic req_valid,
    output logic commit
);

    fill_state_t state_q;
    fill_state_t state_d;

    // Handshake decodes for the current state.
    always_comb begin
        accept    = (state_q == ST_IDLE) && miss_valid;
        beat_take = (state_q == ST_DATA) && mem_rsp_valid;
        idle      = (state_q == ST_IDLE);
        req_valid = (state_q == ST_REQ);
        commit    = (state_q == ST_COMMIT);
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept)                state_d = ST_REQ;
            ST_REQ:    if (mem_req_ready)         state_d = ST_DATA;
            ST_DATA:   if (beat_take && last_beat) state_d = ST_COMMIT;
            ST_COMMIT:                            state_d = ST_IDLE;
            default:                              state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/cwf_line_fill.sv
// Critical-word-first line fill engine (top).
// Takes one read miss, issues one wrapped line read starting at the critical
// chunk, forwards that chunk the cycle after it arrives, and writes the whole
// line out the cycle after the last beat. Assumes memory returns exactly
// BEATS beats per request in wrapped order, and BEATS is a power of two.
module cwf_line_fill #(
    parameter int ADDR_W = 32,
    parameter int BEAT_W = 64,
    parameter int BEATS  = 4,
    localparam int OFF_W      = $clog2(BEAT_W / 8),
    localparam int IDX_W      = $clog2(BEATS),
    localparam int LINE_OFF_W = OFF_W + IDX_W,
    localparam int TAG_W      = ADDR_W - LINE_OFF_W,
    localparam int LINE_W     = BEAT_W * BEATS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [BEAT_W-1:0] mem_rsp_data,
    output logic              fwd_valid,
    output logic [BEAT_W-1:0] fwd_data,
    output logic [OFF_W-1:0]  fwd_offset,
    output logic              line_wr_valid,
    output logic [TAG_W-1:0]  line_wr_addr,
    output logic [LINE_W-1:0] line_wr_data
);

    logic             accept;
    logic             beat_take;
    logic             first_beat;
    logic             last_beat;
    logic [IDX_W-1:0] slot_idx;
    logic [TAG_W-1:0] line_q;
    logic [OFF_W-1:0] off_q;
    logic             fwd_valid_q;
    logic [BEAT_W-1:0] fwd_data_q;

    cwf_fill_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .miss_valid   (miss_valid),
        .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .last_beat    (last_beat),
        .accept       (accept),
        .beat_take    (beat_take),
        .idle         (miss_ready),
        .req_valid    (mem_req_valid),
        .commit       (line_wr_valid)
    );

    cwf_wrap_seq #(.BEATS(BEATS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .start_idx(miss_addr[LINE_OFF_W-1:OFF_W]),
        .step     (beat_take),
        .slot_idx (slot_idx),
        .is_first (first_beat),
        .is_last  (last_beat)
    );

    cwf_line_store #(.BEAT_W(BEAT_W), .BEATS(BEATS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (beat_take),
        .wr_idx   (slot_idx),
        .wr_data  (mem_rsp_data),
        .line_data(line_wr_data)
    );

    // Latch the line address and byte offset of the accepted miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            off_q  <= '0;
        end else if (accept) begin
            line_q <= miss_addr[ADDR_W-1:LINE_OFF_W];
            off_q  <= miss_addr[OFF_W-1:0];
        end
    end

    // Register the critical chunk as a one-cycle forward to the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid_q <= 1'b0;
            fwd_data_q  <= '0;
        end else begin
            fwd_valid_q <= beat_take && first_beat;
            if (beat_take && first_beat) fwd_data_q <= mem_rsp_data;
        end
    end

    // Output assembly: request points at the critical chunk.
    always_comb begin
        mem_req_addr = {line_q, slot_idx, {OFF_W{1'b0}}};
        fwd_valid    = fwd_valid_q;
        fwd_data     = fwd_data_q;
        fwd_offset   = off_q;
        line_wr_addr = line_q;
    end

endmodule

// File: rtl/cwf_line_fill_chk.sv
// Protocol checker for cwf_line_fill, bound to every instance.
module cwf_line_fill_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_valid,
    input logic              miss_ready,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              fwd_valid,
    input logic              line_wr_valid
);

    logic [1:0] fwd_seen;

    // Count forwards since the last accepted miss, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                         fwd_seen <= '0;
        else if (miss_valid && miss_ready)  fwd_seen <= '0;
        else if (fwd_valid && fwd_seen != 2'd3) fwd_seen <= fwd_seen + 2'd1;
    end

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    assert_req_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[2:0] == 3'd0);

    assert_req_follows_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid && miss_ready |=> mem_req_valid);

    assert_fwd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |=> !fwd_valid);

    assert_wr_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        line_wr_valid |=> !line_wr_valid && miss_ready);

    assert_busy_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        line_wr_valid |-> !miss_ready);

    assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid && miss_ready |=> !miss_ready);

    assert_one_fwd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        line_wr_valid |-> fwd_seen == 2'd1);

endmodule

bind cwf_line_fill cwf_line_fill_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .miss_valid   (miss_valid),
    .miss_ready   (miss_ready),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .fwd_valid    (fwd_valid),
    .line_wr_valid(line_wr_valid)
);

// File: tb/tb_cwf_line_fill.sv
module tb_cwf_line_fill;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         miss_valid = 1'b0;
    logic         miss_ready;
    logic [31:0]  miss_addr = '0;
    logic         mem_req_valid;
    logic         mem_req_ready = 1'b0;
    logic [31:0]  mem_req_addr;
    logic         mem_rsp_valid = 1'b0;
    logic [63:0]  mem_rsp_data = '0;
    logic         fwd_valid;
    logic [63:0]  fwd_data;
    logic [2:0]   fwd_offset;
    logic         line_wr_valid;
    logic [26:0]  line_wr_addr;
    logic [255:0] line_wr_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cwf_line_fill dut (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data), .fwd_offset(fwd_offset),
        .line_wr_valid(line_wr_valid), .line_wr_addr(line_wr_addr),
        .line_wr_data(line_wr_data)
    );

    // Unique data for each (line, chunk) pair.
    function automatic logic [63:0] pat(input logic [26:0] line, input logic [1:0] idx);
        return {5'd0, line, 16'hC0DE, 14'd0, idx};
    endfunction

    task automatic check(input string req, input bit ok, input logic [255:0] act,
                         input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Full fill: req_stall cycles before mem_req_ready, gap idle cycles
    // between beats, junk beat during request phase, busy miss during data.
    task automatic run_fill(input logic [31:0] addr, input int req_stall, input int gap,
                            input bit junk, input bit busy_miss);
        logic [26:0]  line = addr[31:5];
        logic [1:0]   s = addr[4:3];
        logic [255:0] exp_line;
        logic [31:0]  exp_req = {addr[31:3], 3'b000};
        for (int k = 0; k < 4; k++) exp_line[64*k +: 64] = pat(line, 2'(k));

        @(negedge clk);
        check("R6 idle ready", miss_ready == 1'b1, 256'(miss_ready), 256'd1);
        miss_valid = 1'b1;
        miss_addr  = addr;
        @(negedge clk);
        miss_valid = 1'b0;
        check("R2 req valid", mem_req_valid == 1'b1, 256'(mem_req_valid), 256'd1);
        check("R2 req addr", mem_req_addr == exp_req, 256'(mem_req_addr), 256'(exp_req));
        check("R6 busy", miss_ready == 1'b0, 256'(miss_ready), 256'd0);
        for (int i = 0; i < req_stall; i++) begin
            if (junk && i == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = 64'hDEAD_BEEF_DEAD_BEEF;
            end
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            check("R2 req held", mem_req_valid && mem_req_addr == exp_req,
                  256'(mem_req_addr), 256'(exp_req));
            if (junk && i == 0)
                check("R7 junk no fwd", fwd_valid == 1'b0, 256'(fwd_valid), 256'd0);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        check("R2 req dropped", mem_req_valid == 1'b0, 256'(mem_req_valid), 256'd0);
        if (busy_miss) begin
            miss_valid = 1'b1;
            miss_addr  = addr ^ 32'h0000_4000;
        end
        for (int n = 0; n < 4; n++) begin
            logic [1:0] slot = s + 2'(n);
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = pat(line, slot);
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (n == 0) begin
                check("R4 fwd valid", fwd_valid == 1'b1, 256'(fwd_valid), 256'd1);
                check("R4 fwd data", fwd_data == pat(line, s), 256'(fwd_data),
                      256'(pat(line, s)));
                check("R4 fwd offset", fwd_offset == addr[2:0], 256'(fwd_offset),
                      256'(addr[2:0]));
            end else begin
                check("R8 single fwd", fwd_valid == 1'b0, 256'(fwd_valid), 256'd0);
            end
            if (busy_miss)
                check("R6 busy miss no req", mem_req_valid == 1'b0 && miss_ready == 1'b0,
                      256'(mem_req_valid), 256'd0);
            if (n == 3 && busy_miss) miss_valid = 1'b0;
            if (n < 3) begin
                check("R5 no early write", line_wr_valid == 1'b0, 256'(line_wr_valid), 256'd0);
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    check("R9 gap no write", line_wr_valid == 1'b0 && fwd_valid == 1'b0,
                          256'(line_wr_valid), 256'd0);
                end
            end
        end
        check("R5 write valid", line_wr_valid == 1'b1, 256'(line_wr_valid), 256'd1);
        check("R5 write addr", line_wr_addr == line, 256'(line_wr_addr), 256'(line));
        check("R3 line data", line_wr_data == exp_line, line_wr_data, exp_line);
        check("R6 busy on write", miss_ready == 1'b0, 256'(miss_ready), 256'd0);
        @(negedge clk);
        check("R5 write one cycle", line_wr_valid == 1'b0, 256'(line_wr_valid), 256'd0);
        check("R6 ready back", miss_ready == 1'b1, 256'(miss_ready), 256'd1);
    endtask

    task automatic test_reset;
        check("R1 miss_ready", miss_ready == 1'b1, 256'(miss_ready), 256'd1);
        check("R1 req idle", mem_req_valid == 1'b0, 256'(mem_req_valid), 256'd0);
        check("R1 fwd idle", fwd_valid == 1'b0, 256'(fwd_valid), 256'd0);
        check("R1 write idle", line_wr_valid == 1'b0, 256'(line_wr_valid), 256'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_fill(32'h0000_0095, 0, 0, 1'b0, 1'b0);   // R3 worked example, start chunk 2
        run_fill(32'h0000_1000, 0, 0, 1'b0, 1'b0);   // R3 start chunk 0
        run_fill(32'h1234_56FF, 3, 2, 1'b0, 1'b0);   // R9 start chunk 3 with stalls and gaps
        run_fill(32'hABCD_EF8C, 2, 1, 1'b1, 1'b0);   // R7 junk beat during request
        run_fill(32'h0F0F_0F52, 1, 0, 1'b0, 1'b1);   // R6 miss offered while busy
        run_fill(32'hFFFF_FFE8, 0, 3, 1'b0, 1'b0);   // R3 top of address space, chunk 1
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule